// File: doc/BRIEF.md
# D-PHY Start-of-Transmission Timing Monitor

This block is a passive observer for one D-PHY data lane. Every sample-clock cycle it receives the decoded low-power line pair and a flag that says the lane is in high-speed mode. It follows the lane through the low-power states. On every transition from low power into high speed it measures three things: how long the lane sat in LP-01, how long it sat in LP-00, and the sum of the two, which is the low plateau that a receiver needs to recognise a start of transmission. It also counts the LP-11 cycles that separated this entry from the end of the previous high-speed burst.

Each entry produces a one-cycle event. The event carries a set of violation flags together with the measured lengths. The flags cover four cases: a direct jump from LP-11 into high speed with no low state at all, a low plateau that is too short, an LP-01 phase that is too short, and an LP-11 exit gap that is too short. All minimums are programmable as cycle counts. Saturating statistics counters record the number of entries and the number of entries in each violation class, and a synchronous clear input zeroes them.

Top module: `dphy_sot_monitor`

## Requirements
- R1: An entry is detected on the clock edge where `hs_active` is sampled 1 after having been sampled 0 on the previous edge. `ev_valid` is high for exactly the one cycle that follows that edge.
- R2: The line pair encodes 2'b11 = LP-11, 2'b01 = LP-01, 2'b00 = LP-00 and 2'b10 = LP-10. `ev_lp01_len` and `ev_lp00_len` give the number of LP-01 and LP-00 cycles sampled since the last LP-11, LP-10 or HS cycle. `ev_plateau_len` is their sum.
- R3: Each measured LP-01 and LP-00 length stops at 2^CNT_W-1 and does not wrap.
- R4: `ev_code` bit 0 (no low state) is set when the plateau is zero. When bit 0 is set, bits 1 and 2 are clear.
- R5: `ev_code` bit 1 (short plateau) is set when the plateau is nonzero and smaller than `min_plateau`.
- R6: `ev_code` bit 2 (short LP-01) is set when the plateau is nonzero and `ev_lp01_len` is smaller than `min_lp01`. This applies even when the plateau itself meets its minimum.
- R7: `ev_gap_len` counts the LP-11 cycles sampled since the last HS cycle, saturating at 2^CNT_W-1. `ev_code` bit 3 (short exit) is set when at least one HS cycle has occurred since reset and the gap is smaller than `min_exit`. The first entry after reset never sets bit 3.
- R8: An LP-11 or LP-10 sample during low power discards any LP-01 and LP-00 cycles gathered before it, so only the final contiguous low sequence is measured.
- R9: All event outputs other than `ev_valid` hold their values until the next entry.
- R10: `cnt_entries` counts entries. `cnt_no_low`, `cnt_short_plateau`, `cnt_short_lp01` and `cnt_short_exit` count entries with code bits 0, 1, 2 and 3 respectively. All of them update in the same cycle as `ev_valid` and saturate at 2^STAT_W-1.
- R11: `clr_stats` sampled high zeroes all statistics counters. An entry on the same edge is counted as the first event after the clear.
- R12: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_lp | input | 2 | Decoded low-power line pair (P in bit 1, N in bit 0) |
| hs_active | input | 1 | Lane is in high-speed mode |
| min_lp01 | input | CNT_W | Minimum LP-01 cycles |
| min_plateau | input | CNT_W | Minimum LP-01 plus LP-00 cycles |
| min_exit | input | CNT_W | Minimum LP-11 cycles after a burst |
| clr_stats | input | 1 | Synchronous clear of the statistics counters |
| ev_valid | output | 1 | One-cycle entry event |
| ev_code | output | 4 | Violation flags of the latest entry |
| ev_lp01_len | output | CNT_W | Measured LP-01 cycles |
| ev_lp00_len | output | CNT_W | Measured LP-00 cycles |
| ev_plateau_len | output | CNT_W+1 | Measured low plateau cycles |
| ev_gap_len | output | CNT_W | LP-11 cycles since the previous burst |
| cnt_entries | output | STAT_W | Total entries |
| cnt_no_low | output | STAT_W | Entries with no low state |
| cnt_short_plateau | output | STAT_W | Entries with a short plateau |
| cnt_short_lp01 | output | STAT_W | Entries with a short LP-01 |
| cnt_short_exit | output | STAT_W | Entries with a short exit gap |

## Verification
The statistics clear and an HS entry can land on the same clock edge. The counters must then read one for the entry's classes and zero for the rest, neither losing the entry nor keeping older counts. The bench provokes this by raising `clr_stats` in the same cycle as `hs_active` after a direct LP-11 jump, then checks `cnt_entries` and the class counters in the following cycle. A clear alone, issued later in mid-burst, must bring every counter back to zero. A behavioural model that handles the clear before the increment checks both cases on every cycle.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int CODE_W      = 4;
  localparam int BIT_NOLOW   = 0;
  localparam int BIT_SHORTPL = 1;
  localparam int BIT_SHORT01 = 2;
  localparam int BIT_SHORTEX = 3;
  localparam int NUM_STATS   = CODE_W + 1;

  typedef enum logic [1:0] {
    LINE_LP00 = 2'b00,
    LINE_LP01 = 2'b01,
    LINE_LP10 = 2'b10,
    LINE_LP11 = 2'b11
  } line_e;
endpackage

// File: rtl/lane_phase_tracker.sv
module lane_phase_tracker
  import dsm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       line_lp,
  input  logic             hs_active,
  output logic             entry_strobe,
  output logic [CNT_W-1:0] lp01_cnt,
  output logic [CNT_W-1:0] lp00_cnt,
  output logic [CNT_W-1:0] gap_cnt,
  output logic             seen_hs
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + ONE;
  endfunction

  logic  hs_prev;
  line_e line_now;

  assign line_now     = line_e'(line_lp);
  assign entry_strobe = hs_active & ~hs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_prev  <= 1'b0;
      lp01_cnt <= '0;
      lp00_cnt <= '0;
      gap_cnt  <= '0;
      seen_hs  <= 1'b0;
    end else begin
      hs_prev <= hs_active;
      if (hs_active) begin
        lp01_cnt <= '0;
        lp00_cnt <= '0;
        gap_cnt  <= '0;
        seen_hs  <= 1'b1;
      end else begin
        unique case (line_now)
          LINE_LP11: begin
            lp01_cnt <= '0;
            lp00_cnt <= '0;
            gap_cnt  <= sat_inc(gap_cnt);
          end
          LINE_LP01: lp01_cnt <= sat_inc(lp01_cnt);
          LINE_LP00: lp00_cnt <= sat_inc(lp00_cnt);
          LINE_LP10: begin
            lp01_cnt <= '0;
            lp00_cnt <= '0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/entry_classifier.sv
module entry_classifier
  import dsm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_strobe,
  input  logic [CNT_W-1:0]  lp01_cnt,
  input  logic [CNT_W-1:0]  lp00_cnt,
  input  logic [CNT_W-1:0]  gap_cnt,
  input  logic              seen_hs,
  input  logic [CNT_W-1:0]  min_lp01,
  input  logic [CNT_W-1:0]  min_plateau,
  input  logic [CNT_W-1:0]  min_exit,
  output logic [CODE_W-1:0] code_now,
  output logic              ev_valid,
  output logic [CODE_W-1:0] ev_code,
  output logic [CNT_W-1:0]  ev_lp01_len,
  output logic [CNT_W-1:0]  ev_lp00_len,
  output logic [CNT_W:0]    ev_plateau_len,
  output logic [CNT_W-1:0]  ev_gap_len
);
  function automatic logic [CNT_W:0] plateau_of(input logic [CNT_W-1:0] a,
                                                input logic [CNT_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [CODE_W-1:0] classify(
    input logic [CNT_W-1:0] l01, input logic [CNT_W-1:0] l00,
    input logic [CNT_W-1:0] gap, input logic seen,
    input logic [CNT_W-1:0] t01, input logic [CNT_W-1:0] tpl,
    input logic [CNT_W-1:0] tex);
    logic [CODE_W-1:0] c;
    logic [CNT_W:0]    pl;
    c  = '0;
    pl = plateau_of(l01, l00);
    if (pl == '0) begin
      c[BIT_NOLOW] = 1'b1;
    end else begin
      c[BIT_SHORTPL] = (pl < {1'b0, tpl});
      c[BIT_SHORT01] = (l01 < t01);
    end
    c[BIT_SHORTEX] = seen && (gap < tex);
    return c;
  endfunction

  assign code_now = classify(lp01_cnt, lp00_cnt, gap_cnt, seen_hs,
                             min_lp01, min_plateau, min_exit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_valid       <= 1'b0;
      ev_code        <= '0;
      ev_lp01_len    <= '0;
      ev_lp00_len    <= '0;
      ev_plateau_len <= '0;
      ev_gap_len     <= '0;
    end else begin
      ev_valid <= entry_strobe;
      if (entry_strobe) begin
        ev_code        <= code_now;
        ev_lp01_len    <= lp01_cnt;
        ev_lp00_len    <= lp00_cnt;
        ev_plateau_len <= plateau_of(lp01_cnt, lp00_cnt);
        ev_gap_len     <= gap_cnt;
      end
    end
  end
endmodule

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] next_count(input logic [W-1:0] v,
                                              input logic c, input logic i);
    logic [W-1:0] base;
    base = c ? '0 : v;
    if (i && !(&base)) base = base + ONE;
    return base;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= next_count(count, clr, inc);
  end
endmodule

// File: rtl/dphy_sot_monitor.sv
module dphy_sot_monitor
  import dsm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        line_lp,
  input  logic              hs_active,
  input  logic [CNT_W-1:0]  min_lp01,
  input  logic [CNT_W-1:0]  min_plateau,
  input  logic [CNT_W-1:0]  min_exit,
  input  logic              clr_stats,
  output logic              ev_valid,
  output logic [3:0]        ev_code,
  output logic [CNT_W-1:0]  ev_lp01_len,
  output logic [CNT_W-1:0]  ev_lp00_len,
  output logic [CNT_W:0]    ev_plateau_len,
  output logic [CNT_W-1:0]  ev_gap_len,
  output logic [STAT_W-1:0] cnt_entries,
  output logic [STAT_W-1:0] cnt_no_low,
  output logic [STAT_W-1:0] cnt_short_plateau,
  output logic [STAT_W-1:0] cnt_short_lp01,
  output logic [STAT_W-1:0] cnt_short_exit
);
  logic              entry_strobe;
  logic [CNT_W-1:0]  lp01_cnt;
  logic [CNT_W-1:0]  lp00_cnt;
  logic [CNT_W-1:0]  gap_cnt;
  logic              seen_hs;
  logic [CODE_W-1:0] code_now;
  logic [NUM_STATS-1:0] stat_inc;
  logic [STAT_W-1:0] stat_val [NUM_STATS];

  lane_phase_tracker #(.CNT_W(CNT_W)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_lp      (line_lp),
    .hs_active    (hs_active),
    .entry_strobe (entry_strobe),
    .lp01_cnt     (lp01_cnt),
    .lp00_cnt     (lp00_cnt),
    .gap_cnt      (gap_cnt),
    .seen_hs      (seen_hs)
  );

  entry_classifier #(.CNT_W(CNT_W)) u_class (
    .clk            (clk),
    .rst_n          (rst_n),
    .entry_strobe   (entry_strobe),
    .lp01_cnt       (lp01_cnt),
    .lp00_cnt       (lp00_cnt),
    .gap_cnt        (gap_cnt),
    .seen_hs        (seen_hs),
    .min_lp01       (min_lp01),
    .min_plateau    (min_plateau),
    .min_exit       (min_exit),
    .code_now       (code_now),
    .ev_valid       (ev_valid),
    .ev_code        (ev_code),
    .ev_lp01_len    (ev_lp01_len),
    .ev_lp00_len    (ev_lp00_len),
    .ev_plateau_len (ev_plateau_len),
    .ev_gap_len     (ev_gap_len)
  );

  assign stat_inc[0] = entry_strobe;

  genvar gi;
  generate
    for (gi = 0; gi < CODE_W; gi++) begin : g_class_inc
      assign stat_inc[gi+1] = entry_strobe & code_now[gi];
    end
    for (gi = 0; gi < NUM_STATS; gi++) begin : g_stat
      stat_counter #(.W(STAT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_stats),
        .inc   (stat_inc[gi]),
        .count (stat_val[gi])
      );
    end
  endgenerate

  assign cnt_entries       = stat_val[0];
  assign cnt_no_low        = stat_val[1+BIT_NOLOW];
  assign cnt_short_plateau = stat_val[1+BIT_SHORTPL];
  assign cnt_short_lp01    = stat_val[1+BIT_SHORT01];
  assign cnt_short_exit    = stat_val[1+BIT_SHORTEX];
endmodule

// File: rtl/dphy_sot_monitor_chk.sv
module dphy_sot_monitor_chk #(
  parameter int CNT_W  = 8,
  parameter int STAT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hs_active,
  input logic              clr_stats,
  input logic [CNT_W-1:0]  min_lp01,
  input logic              ev_valid,
  input logic [3:0]        ev_code,
  input logic [CNT_W-1:0]  ev_lp01_len,
  input logic [CNT_W:0]    ev_plateau_len,
  input logic [STAT_W-1:0] cnt_entries
);
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> !ev_valid);

  assert_event_after_hs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> $past(hs_active));

  assert_nolow_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_code[0]) |-> (ev_plateau_len == '0 && !ev_code[1] && !ev_code[2]));

  assert_short_plateau_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_code[1]) |-> (ev_plateau_len != '0));

  assert_lp01_meets_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_code[0] && !ev_code[2]) |-> (ev_lp01_len >= $past(min_lp01)));

  assert_entries_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_stats |=> (cnt_entries >= $past(cnt_entries)));

  assert_entries_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (cnt_entries != '0));
endmodule

bind dphy_sot_monitor dphy_sot_monitor_chk #(.CNT_W(CNT_W), .STAT_W(STAT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .hs_active      (hs_active),
  .clr_stats      (clr_stats),
  .min_lp01       (min_lp01),
  .ev_valid       (ev_valid),
  .ev_code        (ev_code),
  .ev_lp01_len    (ev_lp01_len),
  .ev_plateau_len (ev_plateau_len),
  .cnt_entries    (cnt_entries)
);

// File: tb/dphy_sot_monitor_tb.sv
module dphy_sot_monitor_tb;
  localparam int CNT_W  = 8;
  localparam int STAT_W = 5;
  localparam int MAXC   = (1 << CNT_W) - 1;
  localparam int MAXS   = (1 << STAT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] line_lp = 2'b11;
  logic hs_active = 1'b0;
  logic clr_stats = 1'b0;
  logic [CNT_W-1:0] min_lp01 = 8'd3;
  logic [CNT_W-1:0] min_plateau = 8'd5;
  logic [CNT_W-1:0] min_exit = 8'd6;

  logic              ev_valid;
  logic [3:0]        ev_code;
  logic [CNT_W-1:0]  ev_lp01_len, ev_lp00_len, ev_gap_len;
  logic [CNT_W:0]    ev_plateau_len;
  logic [STAT_W-1:0] cnt_entries, cnt_no_low, cnt_short_plateau, cnt_short_lp01, cnt_short_exit;

  always #10 clk = ~clk;

  dphy_sot_monitor #(.CNT_W(CNT_W), .STAT_W(STAT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_lp(line_lp), .hs_active(hs_active),
    .min_lp01(min_lp01), .min_plateau(min_plateau), .min_exit(min_exit),
    .clr_stats(clr_stats), .ev_valid(ev_valid), .ev_code(ev_code),
    .ev_lp01_len(ev_lp01_len), .ev_lp00_len(ev_lp00_len),
    .ev_plateau_len(ev_plateau_len), .ev_gap_len(ev_gap_len),
    .cnt_entries(cnt_entries), .cnt_no_low(cnt_no_low),
    .cnt_short_plateau(cnt_short_plateau), .cnt_short_lp01(cnt_short_lp01),
    .cnt_short_exit(cnt_short_exit)
  );

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m01 = 0, m00 = 0, mgap = 0, mseen = 0, mprev = 0;
  int x_valid = 0, x_code = 0, x_l01 = 0, x_l00 = 0, x_pl = 0, x_gap = 0;
  int x_stat [5] = '{0, 0, 0, 0, 0};

  function automatic int bump(input int v, input int lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m01 = 0; m00 = 0; mgap = 0; mseen = 0; mprev = 0;
      x_valid = 0; x_code = 0; x_l01 = 0; x_l00 = 0; x_pl = 0; x_gap = 0;
      for (int k = 0; k < 5; k++) x_stat[k] = 0;
    end else begin
      bit ent;
      int code;
      ent = hs_active && (mprev == 0);
      x_valid = ent ? 1 : 0;
      if (clr_stats) for (int k = 0; k < 5; k++) x_stat[k] = 0;
      if (ent) begin
        int pl;
        pl = m01 + m00;
        code = 0;
        if (pl == 0) code += 1;
        else begin
          if (pl < int'(min_plateau)) code += 2;
          if (m01 < int'(min_lp01)) code += 4;
        end
        if (mseen != 0 && mgap < int'(min_exit)) code += 8;
        x_code = code; x_l01 = m01; x_l00 = m00; x_pl = pl; x_gap = mgap;
        x_stat[0] = bump(x_stat[0], MAXS);
        for (int k = 0; k < 4; k++)
          if (code[k]) x_stat[k+1] = bump(x_stat[k+1], MAXS);
      end
      if (hs_active) begin
        m01 = 0; m00 = 0; mgap = 0; mseen = 1;
      end else if (line_lp == 2'b11) begin
        m01 = 0; m00 = 0; mgap = bump(mgap, MAXC);
      end else if (line_lp == 2'b01) m01 = bump(m01, MAXC);
      else if (line_lp == 2'b00) m00 = bump(m00, MAXC);
      else begin
        m01 = 0; m00 = 0;
      end
      mprev = hs_active ? 1 : 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    chk(ev_valid == x_valid[0], "R1 ev_valid", ev_valid, x_valid);
    chk(ev_code == x_code[3:0], "R4-code", ev_code, x_code);
    chk(ev_lp01_len == x_l01[CNT_W-1:0], "R2 lp01", ev_lp01_len, x_l01);
    chk(ev_lp00_len == x_l00[CNT_W-1:0], "R2 lp00", ev_lp00_len, x_l00);
    chk(ev_plateau_len == x_pl[CNT_W:0], "R2 plateau", ev_plateau_len, x_pl);
    chk(ev_gap_len == x_gap[CNT_W-1:0], "R7 gap", ev_gap_len, x_gap);
    chk(cnt_entries == x_stat[0][STAT_W-1:0], "R10 entries", cnt_entries, x_stat[0]);
    chk(cnt_no_low == x_stat[1][STAT_W-1:0], "R10 no_low", cnt_no_low, x_stat[1]);
    chk(cnt_short_plateau == x_stat[2][STAT_W-1:0], "R10 short_plateau", cnt_short_plateau, x_stat[2]);
    chk(cnt_short_lp01 == x_stat[3][STAT_W-1:0], "R10 short_lp01", cnt_short_lp01, x_stat[3]);
    chk(cnt_short_exit == x_stat[4][STAT_W-1:0], "R10 short_exit", cnt_short_exit, x_stat[4]);
  end

  task automatic drive(input logic [1:0] l, input logic h, input int n);
    repeat (n) begin
      @(negedge clk);
      line_lp = l;
      hs_active = h;
    end
  endtask

  task automatic hs_entry(input int n11, input int n01, input int n00,
                          input int nhs, input int exp_code, input string tag);
    drive(2'b11, 1'b0, n11);
    drive(2'b01, 1'b0, n01);
    drive(2'b00, 1'b0, n00);
    @(negedge clk);
    hs_active = 1'b1;
    @(negedge clk);
    chk(ev_valid == 1'b1, {tag, " pulse"}, ev_valid, 1);
    chk(ev_code == exp_code[3:0], tag, ev_code, exp_code);
    drive(2'b00, 1'b1, nhs);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(ev_valid == 0 && ev_code == 0 && cnt_entries == 0 && cnt_short_exit == 0,
        "R12 reset", ev_code, 0);
    rst_n = 1'b1;
    // first entry: no exit check yet (R7), clean sequence
    hs_entry(10, 4, 6, 4, 0, "R7 first entry clean");
    chk(ev_plateau_len == 10, "R2 plateau sum", ev_plateau_len, 10);
    // direct LP-11 to HS (R4)
    hs_entry(8, 0, 0, 3, 1, "R4 direct jump");
    // short plateau, short LP-01, short exit (R5 R6 R7)
    hs_entry(3, 1, 2, 3, 14, "R5 short plateau with R6 R7");
    chk(ev_gap_len == 3, "R7 gap length", ev_gap_len, 3);
    // long plateau but short LP-01 (R6)
    hs_entry(7, 1, 20, 3, 4, "R6 short lp01 long plateau");
    drive(2'b00, 1'b1, 3);
    chk(ev_lp00_len == 20 && ev_valid == 0, "R9 hold lp00", ev_lp00_len, 20);
    // direct jump with short exit gap
    hs_entry(2, 0, 0, 2, 9, "R4 R7 direct and short exit");
    // R8: LP-11 and LP-10 interruptions discard earlier low cycles
    drive(2'b11, 1'b0, 7);
    drive(2'b01, 1'b0, 5);
    drive(2'b11, 1'b0, 1);
    drive(2'b00, 1'b0, 4);
    drive(2'b10, 1'b0, 1);
    hs_entry(0, 3, 3, 2, 0, "R8 restart measurement");
    chk(ev_lp01_len == 3 && ev_lp00_len == 3, "R8 lengths", ev_lp01_len, 3);
    // R3: saturation of measured lengths
    hs_entry(7, 300, 300, 2, 0, "R3 long states");
    chk(ev_lp01_len == MAXC, "R3 lp01 saturates", ev_lp01_len, MAXC);
    chk(ev_lp00_len == MAXC, "R3 lp00 saturates", ev_lp00_len, MAXC);
    chk(ev_plateau_len == 2 * MAXC, "R3 plateau", ev_plateau_len, 2 * MAXC);
    // R11: clear on the same edge as an entry
    drive(2'b11, 1'b0, 6);
    @(negedge clk);
    hs_active = 1'b1;
    clr_stats = 1'b1;
    @(negedge clk);
    clr_stats = 1'b0;
    chk(cnt_entries == 1, "R11 entry with clear", cnt_entries, 1);
    chk(cnt_no_low == 1 && cnt_short_plateau == 0, "R11 class counts", cnt_no_low, 1);
    drive(2'b00, 1'b1, 2);
    @(negedge clk);
    clr_stats = 1'b1;
    @(negedge clk);
    clr_stats = 1'b0;
    chk(cnt_entries == 0 && cnt_no_low == 0, "R11 clear alone", cnt_entries, 0);
    // R10: statistics saturate
    for (int i = 0; i < MAXS + 6; i++) hs_entry(2, 0, 0, 1, 9, "R10 repeated direct");
    chk(cnt_entries == MAXS, "R10 entries saturate", cnt_entries, MAXS);
    chk(cnt_short_exit == MAXS, "R10 class saturate", cnt_short_exit, MAXS);
    chk(cnt_short_lp01 == 0, "R10 untouched class", cnt_short_lp01, 0);
    drive(2'b11, 1'b0, 4);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule